// File: doc/BRIEF.md
# Dual-Channel Serial Controller Host Register Layer

This block sits between a host processor bus and two identical asynchronous serial channels. Every access carries a chip select, active-low read and write strobes, a 3-bit register address and a channel-select line. The block sends each access to one of two register banks. Each bank holds an interrupt enable byte, line control, modem control, a scratch byte, a 16-bit baud divisor and a pin-function byte. It also passes pulses toward the transmit and receive FIFOs and the FIFO-control logic of the selected channel. Status bytes that other logic produces are presented to the host on a read.

Each channel has three outputs: an active-low data-terminal-ready line, an active-low request-to-send line and one multipurpose pin. The pin-function byte chooses what the multipurpose pin carries. It can carry the inverted interrupt-output enable from modem control, the 16x baud clock of the channel, or the active-low receive-ready request of the channel's receive FIFO. The serial shifters, the FIFO storage and the baud counters are outside this block.

A bus access acts once, on the first clock cycle in which its strobe is seen low. Read data is driven combinationally for as long as the read strobe is held. Bit index 0 of every per-channel port belongs to channel A and bit index 1 belongs to channel B.

Top module: `duart_regs`

## Requirements
- R1: While `busCsN` is low, `chanSel` high addresses channel A (index 0) and `chanSel` low addresses channel B (index 1). Each channel's registers are independent of the other channel's.
- R2: The scratch byte at address 7 reads back exactly the value last written to it. The interrupt enable byte (address 1), line control (address 3) and modem control (address 4) also read back as written.
- R3: When line-control bit 7 is 0, a write to address 0 raises `txPush` of the selected channel for exactly one cycle, with the byte on `txData`. A write to address 2 raises `fcrWr` of that channel for one cycle.
- R4: When line-control bit 7 is 0, a read of address 0 returns that channel's `rxData`. It raises `rxPop` of that channel only in the first cycle of the read strobe.
- R5: Reads of addresses 2, 5 and 6 return that channel's `intStatus`, `lineStatus` and `modemStatus` inputs.
- R6: When line-control bit 7 is 1, addresses 0, 1 and 2 reach the divisor low byte, the divisor high byte and the pin-function byte. All three are readable and writable, and none of these accesses raises `txPush`, `rxPop` or `fcrWr`. The `divisor` output is {high, low}.
- R7: `dtrN` equals the inverse of modem-control bit 0, and `rtsN` equals the inverse of modem-control bit 1.
- R8: When pin-function bits 2:1 are 00 or 11, `mfN` is the inverse of modem-control bit 3.
- R9: When pin-function bits 2:1 are 01, `mfN` follows the channel's `baudClk16` input.
- R10: When pin-function bits 2:1 are 10, `mfN` follows the channel's `rxRdyN` input.
- R11: The active-high synchronous `rst` clears every register. After reset, `dtrN`, `rtsN` and `mfN` are all high and `divisor` is 0.
- R12: With `busCsN` high, strobes have no effect and `rdData` is 0. `rdData` is also 0 whenever no read is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busCsN | input | 1 | Chip select, active low |
| busRdN | input | 1 | Read strobe, active low |
| busWrN | input | 1 | Write strobe, active low |
| busAddr | input | 3 | Register address |
| chanSel | input | 1 | High selects channel A, low selects channel B |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Host read data, 0 when idle |
| rxData | input | 2x8 | Receive FIFO head byte per channel |
| intStatus | input | 2x8 | Interrupt status byte per channel |
| lineStatus | input | 2x8 | Line status byte per channel |
| modemStatus | input | 2x8 | Modem status byte per channel |
| baudClk16 | input | 2 | 16x baud clock per channel |
| rxRdyN | input | 2 | Receive-ready request per channel, active low |
| txPush | output | 2 | Transmit FIFO push pulse per channel |
| txData | output | 8 | Byte to push into the transmit FIFO |
| rxPop | output | 2 | Receive FIFO pop pulse per channel |
| fcrWr | output | 2 | FIFO control write pulse per channel, data on txData |
| ierOut | output | 2x8 | Interrupt enable byte per channel |
| lcrOut | output | 2x8 | Line control byte per channel |
| mcrOut | output | 2x8 | Modem control byte per channel |
| divisor | output | 2x16 | Baud divisor per channel |
| dtrN | output | 2 | Data terminal ready per channel, active low |
| rtsN | output | 2 | Request to send per channel, active low |
| mfN | output | 2 | Multipurpose pin per channel |

## Verification
A register that holds the wrong value shows up on `rdData` in the very read that addresses it. For modem control and the pin-function byte, the fault shows up on `dtrN`, `rtsN` or `mfN` in the cycle right after the write edge. If the channel steering is wrong, the other channel's scratch or status byte appears on `rdData`, or the push and pop pulses land on the wrong bit. A stuck divisor-access bit is visible at once in two ways: an address-0 read returns the divisor byte instead of receive data, and a FIFO pulse is missing or appears when it should not.

// File: rtl/duart_pkg.sv
package duart_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int CH_N   = 2;
  localparam int DIV_W  = 2 * DATA_W;

  typedef enum logic [3:0] {
    SEL_HOLD, SEL_IER, SEL_STAT_FCTL, SEL_LCR, SEL_MCR,
    SEL_LSR, SEL_MSR, SEL_SCR, SEL_DLL, SEL_DLM, SEL_AFR
  } regSel_e;

  typedef struct packed {
    logic [CH_N-1:0] wrEn;
    logic [CH_N-1:0] rdFire;
    logic [CH_N-1:0] rdSel;
    regSel_e         sel;
  } busStrobe_t;

  localparam logic [1:0] PIN_BAUD  = 2'b01;
  localparam logic [1:0] PIN_RXRDY = 2'b10;
  localparam int DLAB_BIT = 7;
  localparam int OP2_BIT  = 3;
endpackage

// File: rtl/duart_ctrl.sv
module duart_ctrl
  import duart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              csN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chanSel,
  input  logic [CH_N-1:0]   dlab,
  output busStrobe_t        strobe
);
  logic rdAct, wrAct, rdPrev, wrPrev;
  logic chIdx;
  logic [CH_N-1:0] chOneHot;
  regSel_e selNext;

  assign rdAct = !csN && !rdN;
  assign wrAct = !csN && !wrN;
  assign chIdx = ~chanSel;
  assign chOneHot = CH_N'(1) << chIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPrev <= 1'b0;
      wrPrev <= 1'b0;
    end else begin
      rdPrev <= rdAct;
      wrPrev <= wrAct;
    end
  end

  always_comb begin
    case (addr)
      3'd0:    selNext = dlab[chIdx] ? SEL_DLL : SEL_HOLD;
      3'd1:    selNext = dlab[chIdx] ? SEL_DLM : SEL_IER;
      3'd2:    selNext = dlab[chIdx] ? SEL_AFR : SEL_STAT_FCTL;
      3'd3:    selNext = SEL_LCR;
      3'd4:    selNext = SEL_MCR;
      3'd5:    selNext = SEL_LSR;
      3'd6:    selNext = SEL_MSR;
      default: selNext = SEL_SCR;
    endcase
  end

  always_comb begin
    strobe.sel    = selNext;
    strobe.wrEn   = (wrAct && !wrPrev) ? chOneHot : '0;
    strobe.rdFire = (rdAct && !rdPrev) ? chOneHot : '0;
    strobe.rdSel  = rdAct ? chOneHot : '0;
  end
endmodule

// File: rtl/duart_pinmux.sv
module duart_pinmux
  import duart_pkg::*;
(
  input  logic [1:0] code,
  input  logic       op2En,
  input  logic       baudClk16,
  input  logic       rxRdyN,
  output logic       mfN
);
  always_comb begin
    case (code)
      PIN_BAUD:  mfN = baudClk16;
      PIN_RXRDY: mfN = rxRdyN;
      default:   mfN = ~op2En;
    endcase
  end
endmodule

// File: rtl/duart_bank.sv
module duart_bank
  import duart_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdFire,
  input  logic              rdSel,
  input  regSel_e           sel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxByte,
  input  logic [DATA_W-1:0] intStat,
  input  logic [DATA_W-1:0] lineStat,
  input  logic [DATA_W-1:0] modemStat,
  input  logic              baudClk16,
  input  logic              rxRdyN,
  output logic [DATA_W-1:0] rdByte,
  output logic              txPush,
  output logic              fcrWr,
  output logic              rxPop,
  output logic [DATA_W-1:0] ierQ,
  output logic [DATA_W-1:0] lcrQ,
  output logic [DATA_W-1:0] mcrQ,
  output logic [DIV_W-1:0]  divQ,
  output logic              dtrN,
  output logic              rtsN,
  output logic              mfN
);
  logic [DATA_W-1:0] ier, lcr, mcr, scr, dll, dlm, afr;

  always_ff @(posedge clk) begin
    if (rst) begin
      ier <= '0; lcr <= '0; mcr <= '0; scr <= '0;
      dll <= '0; dlm <= '0; afr <= '0;
    end else if (wrEn) begin
      case (sel)
        SEL_IER: ier <= wrData;
        SEL_LCR: lcr <= wrData;
        SEL_MCR: mcr <= wrData;
        SEL_SCR: scr <= wrData;
        SEL_DLL: dll <= wrData;
        SEL_DLM: dlm <= wrData;
        SEL_AFR: afr <= wrData;
        default: ;
      endcase
    end
  end

  assign txPush = wrEn && (sel == SEL_HOLD);
  assign fcrWr  = wrEn && (sel == SEL_STAT_FCTL);
  assign rxPop  = rdFire && (sel == SEL_HOLD);

  always_comb begin
    rdByte = '0;
    if (rdSel) begin
      case (sel)
        SEL_HOLD:      rdByte = rxByte;
        SEL_IER:       rdByte = ier;
        SEL_STAT_FCTL: rdByte = intStat;
        SEL_LCR:       rdByte = lcr;
        SEL_MCR:       rdByte = mcr;
        SEL_LSR:       rdByte = lineStat;
        SEL_MSR:       rdByte = modemStat;
        SEL_SCR:       rdByte = scr;
        SEL_DLL:       rdByte = dll;
        SEL_DLM:       rdByte = dlm;
        SEL_AFR:       rdByte = afr;
        default:       rdByte = '0;
      endcase
    end
  end

  assign ierQ = ier;
  assign lcrQ = lcr;
  assign mcrQ = mcr;
  assign divQ = {dlm, dll};
  assign dtrN = ~mcr[0];
  assign rtsN = ~mcr[1];

  duart_pinmux u_mux (
    .code      (afr[2:1]),
    .op2En     (mcr[OP2_BIT]),
    .baudClk16 (baudClk16),
    .rxRdyN    (rxRdyN),
    .mfN       (mfN)
  );
endmodule

// File: rtl/duart_regs.sv
module duart_regs
  import duart_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         busCsN,
  input  logic                         busRdN,
  input  logic                         busWrN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         chanSel,
  input  logic [DATA_W-1:0]            wrData,
  output logic [DATA_W-1:0]            rdData,
  input  logic [CH_N-1:0][DATA_W-1:0]  rxData,
  input  logic [CH_N-1:0][DATA_W-1:0]  intStatus,
  input  logic [CH_N-1:0][DATA_W-1:0]  lineStatus,
  input  logic [CH_N-1:0][DATA_W-1:0]  modemStatus,
  input  logic [CH_N-1:0]              baudClk16,
  input  logic [CH_N-1:0]              rxRdyN,
  output logic [CH_N-1:0]              txPush,
  output logic [DATA_W-1:0]            txData,
  output logic [CH_N-1:0]              rxPop,
  output logic [CH_N-1:0]              fcrWr,
  output logic [CH_N-1:0][DATA_W-1:0]  ierOut,
  output logic [CH_N-1:0][DATA_W-1:0]  lcrOut,
  output logic [CH_N-1:0][DATA_W-1:0]  mcrOut,
  output logic [CH_N-1:0][DIV_W-1:0]   divisor,
  output logic [CH_N-1:0]              dtrN,
  output logic [CH_N-1:0]              rtsN,
  output logic [CH_N-1:0]              mfN
);
  busStrobe_t strobe;
  logic [CH_N-1:0] dlab;
  logic [CH_N-1:0][DATA_W-1:0] bankRd;

  duart_ctrl u_ctrl (
    .clk(clk), .rst(rst), .csN(busCsN), .rdN(busRdN), .wrN(busWrN),
    .addr(busAddr), .chanSel(chanSel), .dlab(dlab), .strobe(strobe)
  );

  for (genvar ch = 0; ch < CH_N; ch++) begin : g_bank
    duart_bank u_bank (
      .clk(clk), .rst(rst),
      .wrEn(strobe.wrEn[ch]), .rdFire(strobe.rdFire[ch]),
      .rdSel(strobe.rdSel[ch]), .sel(strobe.sel),
      .wrData(wrData), .rxByte(rxData[ch]), .intStat(intStatus[ch]),
      .lineStat(lineStatus[ch]), .modemStat(modemStatus[ch]),
      .baudClk16(baudClk16[ch]), .rxRdyN(rxRdyN[ch]),
      .rdByte(bankRd[ch]), .txPush(txPush[ch]), .fcrWr(fcrWr[ch]),
      .rxPop(rxPop[ch]), .ierQ(ierOut[ch]), .lcrQ(lcrOut[ch]),
      .mcrQ(mcrOut[ch]), .divQ(divisor[ch]),
      .dtrN(dtrN[ch]), .rtsN(rtsN[ch]), .mfN(mfN[ch])
    );
    assign dlab[ch] = lcrOut[ch][DLAB_BIT];
  end

  always_comb begin
    rdData = '0;
    for (int ch = 0; ch < CH_N; ch++) rdData |= bankRd[ch];
  end

  assign txData = wrData;
endmodule

// File: rtl/duart_regs_chk.sv
module duart_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       busCsN,
  input logic       busWrN,
  input logic [7:0] rdData,
  input logic [1:0] txPush,
  input logic [1:0] rxPop,
  input logic [1:0] dtrN,
  input logic [1:0] rtsN,
  input logic [1:0] mfN
);
  // R3
  push_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(txPush));
  // R3
  push_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (|txPush) |-> (!busCsN && !busWrN));
  // R4
  pop_single_chk: assert property (@(posedge clk) disable iff (rst)
    (|rxPop) |=> !(|rxPop));
  // R7
  dtr_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dtrN) |-> $past(!busCsN && !busWrN));
  // R11
  reset_pins_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (dtrN == 2'b11 && rtsN == 2'b11 && mfN == 2'b11));
  // R12
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    busCsN |-> (rdData == 8'h00));
endmodule

bind duart_regs duart_regs_chk u_chk (.*);

// File: tb/sim_duart_regs.sv
module sim_duart_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 18;
  // {isWrite, chanA, addr, data, expected}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 3'd7, 8'h5A, 8'h00},  // R2 scratch A
    {1'b1, 1'b0, 3'd7, 8'hA5, 8'h00},  // R1 scratch B
    {1'b0, 1'b1, 3'd7, 8'h00, 8'h5A},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'hA5},
    {1'b1, 1'b1, 3'd1, 8'h0F, 8'h00},
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h0F},
    {1'b0, 1'b0, 3'd1, 8'h00, 8'h00},
    {1'b1, 1'b0, 3'd3, 8'h1B, 8'h00},
    {1'b0, 1'b0, 3'd3, 8'h00, 8'h1B},
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h00},
    {1'b0, 1'b1, 3'd2, 8'h00, 8'hC1},  // R5
    {1'b0, 1'b0, 3'd2, 8'h00, 8'hC2},
    {1'b0, 1'b1, 3'd5, 8'h00, 8'h60},
    {1'b0, 1'b0, 3'd6, 8'h00, 8'hB1},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h11},  // R4
    {1'b0, 1'b0, 3'd0, 8'h00, 8'h22},
    {1'b1, 1'b1, 3'd4, 8'h0A, 8'h00},
    {1'b0, 1'b1, 3'd4, 8'h00, 8'h0A}
  };

  logic clk = 0, rst = 1;
  logic busCsN = 1, busRdN = 1, busWrN = 1, chanSel = 1;
  logic [2:0] busAddr = '0;
  logic [7:0] wrData = '0, rdData, txData;
  logic [1:0][7:0] rxData, intStatus, lineStatus, modemStatus;
  logic [1:0] baudClk16 = '0, rxRdyN = 2'b11;
  logic [1:0] txPush, rxPop, fcrWr, dtrN, rtsN, mfN;
  logic [1:0][7:0] ierOut, lcrOut, mcrOut;
  logic [1:0][15:0] divisor;
  int compared = 0, mismatched = 0;
  logic [1:0] seenPush, seenFcr;
  logic [7:0] seenTx, rv;
  logic [1:0] p0, p1;

  always #(CLK_PERIOD/2) clk = ~clk;

  duart_regs u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic chA, input logic [2:0] a, input logic [7:0] d,
                          input logic useCs = 1'b1);
    @(posedge clk); #1;
    chanSel = chA; busAddr = a; wrData = d; busCsN = !useCs; busWrN = 0;
    @(negedge clk);
    seenPush = txPush; seenFcr = fcrWr; seenTx = txData;
    @(posedge clk); #1;
    busCsN = 1; busWrN = 1;
  endtask

  task automatic busRead(input logic chA, input logic [2:0] a, output logic [7:0] v,
                         output logic [1:0] pop0, output logic [1:0] pop1);
    @(posedge clk); #1;
    chanSel = chA; busAddr = a; busCsN = 0; busRdN = 0;
    @(negedge clk);
    v = rdData; pop0 = rxPop;
    @(posedge clk); #1;
    @(negedge clk);
    pop1 = rxPop;
    @(posedge clk); #1;
    busCsN = 1; busRdN = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rxData = {8'h22, 8'h11};
    intStatus = {8'hC2, 8'hC1};
    lineStatus = {8'h61, 8'h60};
    modemStatus = {8'hB1, 8'hB0};
    repeat (3) @(posedge clk); #1; rst = 0;
    @(negedge clk);
    // R11 reset state
    check("R11 dtrN", dtrN, 2'b11);
    check("R11 rtsN", rtsN, 2'b11);
    check("R11 mfN", mfN, 2'b11);
    check("R11 divisor", divisor, 32'h0);
    check("R12 idle rdData", rdData, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][20]) busWrite(VEC[i][19], VEC[i][18:16], VEC[i][15:8]);
      else begin
        busRead(VEC[i][19], VEC[i][18:16], rv, p0, p1);
        check($sformatf("R1/R2/R5 vector %0d", i), rv, VEC[i][7:0]);
      end
    end

    // R7 and R8 after MCR A = 0A
    @(negedge clk);
    check("R7 rtsN A", rtsN, 2'b10);
    check("R7 dtrN A", dtrN, 2'b11);
    check("R8 mfN op2 A", mfN, 2'b10);
    busWrite(1'b0, 3'd4, 8'h01);
    @(negedge clk);
    check("R7 dtrN B", dtrN, 2'b01);
    busWrite(1'b0, 3'd4, 8'h02);
    @(negedge clk);
    check("R7 dtr/rts B", {dtrN, rtsN}, 4'b11_00);

    // R3 push and FIFO-control pulses
    busWrite(1'b1, 3'd0, 8'h3C);
    check("R3 txPush A", seenPush, 2'b01);
    check("R3 txData", seenTx, 8'h3C);
    busWrite(1'b0, 3'd2, 8'h07);
    check("R3 fcrWr B", seenFcr, 2'b10);

    // R4 pop pulse only in the first strobe cycle
    busRead(1'b1, 3'd0, rv, p0, p1);
    check("R4 pop first cycle", p0, 2'b01);
    check("R4 pop second cycle", p1, 2'b00);
    busRead(1'b0, 3'd0, rv, p0, p1);
    check("R4 pop B", p0, 2'b10);

    // R6 divisor bank on channel A
    busWrite(1'b1, 3'd3, 8'h83);
    busWrite(1'b1, 3'd0, 8'h34);
    check("R6 no push with dlab", seenPush, 2'b00);
    busWrite(1'b1, 3'd1, 8'h12);
    busWrite(1'b1, 3'd2, 8'h02);
    check("R6 no fcrWr with dlab", seenFcr, 2'b00);
    busRead(1'b1, 3'd0, rv, p0, p1);
    check("R6 read DLL", rv, 8'h34);
    check("R6 no pop with dlab", p0, 2'b00);
    busRead(1'b1, 3'd1, rv, p0, p1);
    check("R6 read DLM", rv, 8'h12);
    busRead(1'b1, 3'd2, rv, p0, p1);
    check("R6 read AFR", rv, 8'h02);
    check("R6 divisor A", divisor[0], 16'h1234);
    busRead(1'b0, 3'd0, rv, p0, p1);
    check("R1 B unaffected by A dlab", rv, 8'h22);

    // R9 baud clock function (AFR code 01)
    @(posedge clk); #1 baudClk16 = 2'b01;
    @(negedge clk); check("R9 mfN follows baud high", mfN[0], 1'b1);
    @(posedge clk); #1 baudClk16 = 2'b00;
    @(negedge clk); check("R9 mfN follows baud low", mfN[0], 1'b0);
    // R10 receive-ready function (code 10)
    busWrite(1'b1, 3'd2, 8'h04);
    @(posedge clk); #1 rxRdyN = 2'b10;
    @(negedge clk); check("R10 mfN rxRdy low", mfN[0], 1'b0);
    @(posedge clk); #1 rxRdyN = 2'b11;
    @(negedge clk); check("R10 mfN rxRdy high", mfN[0], 1'b1);
    // R8 code 11 behaves as OP2, MCR A still 0A
    busWrite(1'b1, 3'd2, 8'h06);
    @(negedge clk); check("R8 code 11 op2", mfN[0], 1'b0);
    busWrite(1'b1, 3'd4, 8'h00);
    @(negedge clk); check("R8 op2 disabled", mfN[0], 1'b1);
    busWrite(1'b1, 3'd3, 8'h03);
    busRead(1'b1, 3'd0, rv, p0, p1);
    check("R6 dlab cleared gives rx data", rv, 8'h11);

    // R12 chip select high: no effect
    busWrite(1'b1, 3'd7, 8'hFF, 1'b0);
    check("R12 no push without cs", seenPush, 2'b00);
    @(posedge clk); #1 busRdN = 0; busCsN = 1;
    @(negedge clk); check("R12 rdData without cs", rdData, 8'h00);
    @(posedge clk); #1 busRdN = 1;
    busRead(1'b1, 3'd7, rv, p0, p1);
    check("R12 scratch unchanged", rv, 8'h5A);

    // R11 reset clears everything
    busWrite(1'b1, 3'd4, 8'h03);
    @(posedge clk); #1 rst = 1;
    repeat (2) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check("R11 pins after reset", {dtrN, rtsN, mfN}, 6'b111111);
    check("R11 divisor after reset", divisor, 32'h0);
    check("R11 lcr after reset", lcrOut, 16'h0);
    busRead(1'b1, 3'd7, rv, p0, p1);
    check("R11 scratch after reset", rv, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule